// File: doc/BRIEF.md
# Single-Channel PWM Generator with Edge or Center Alignment

This block drives one pulse-width-modulated output from a channel counter that steps on a selectable tick. The counter value is compared against a latched period value and a latched duty value, and the output is set to one of two levels by that comparison. The step tick is either a power-of-two division of the master clock, from 1 to 1024, or one of two divided-clock strobes that circuitry outside the block supplies.

Two counting shapes are available. In edge-aligned operation the counter runs up from 0 to period−1 and wraps, so one output period lasts X × period master-clock cycles. In center-aligned operation the counter climbs to the period value and falls back to 0, which doubles the output period to 2 × X × period cycles and places the active window symmetrically around the turning point. In both shapes the active share of the period is (period − duty)/period. Configuration arrives on plain input ports. The shape, the period and the duty are captured only when a new period begins, so a change made mid-period never produces a runt pulse.

Top module: `pwm_channel`

## Requirements
- R1: While reset is asserted (active-low `rst_n`, synchronous), and at every cycle after the channel has been disabled, the output sits at the inactive level, which is the inverse of `pol_i`.
- R2: Edge-aligned mode (`center_i` = 0): the counter steps 0, 1, …, P−1, 0, … once per tick. The output is active while the count is ≥ D, so one period lasts X × P master-clock cycles with P−D active ticks.
- R3: Center-aligned mode (`center_i` = 1): the counter steps 0 up to P, then down to 1, then returns to 0, giving 2P ticks per period. The output is active while the count is ≥ D on the rising half (counts 0 … P−1) and while the count is > D on the falling half (counts P … 1). This gives 2(P−D) active ticks centred on the turning point.
- R4: `clk_sel_i` values 0 to 10 choose a step of X = 2^code master-clock cycles. The first step comes X cycles after the first clock edge that sees `en_i` high, and the next steps follow every X cycles.
- R5: `clk_sel_i` = 11 steps the counter once per cycle in which `tick_a_i` is high. `clk_sel_i` = 12 does the same with `tick_b_i`. The strobe that is not selected has no effect.
- R6: `clk_sel_i` values 13 to 15 stop the counter. It keeps its value no matter what either strobe does.
- R7: With `pol_i` = 1 the active level is 1. With `pol_i` = 0 the active level is 0 and the inactive level is 1. The polarity acts on the output combinationally.
- R8: A duty value D ≥ P keeps the output inactive for the whole period in both modes. D = 0 keeps it active for the whole period.
- R9: `period_i`, `duty_i` and `center_i` are captured only on the step that returns the counter to 0, or on any edge while `en_i` is low. A value changed mid-period takes effect from the next period.
- R10: When `en_i` falls, the counter is cleared on that edge. When the channel is enabled again, counting restarts from 0 with the rising half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Channel enable; low clears the counter |
| center_i | input | 1 | 1 selects center-aligned counting, 0 selects edge-aligned |
| pol_i | input | 1 | Level driven while the output is active |
| clk_sel_i | input | 4 | Step source: 0–10 prescale 2^n, 11 strobe A, 12 strobe B, 13–15 stopped |
| tick_a_i | input | 1 | External divided-clock strobe A |
| tick_b_i | input | 1 | External divided-clock strobe B |
| period_i | input | CNT_W (16) | Period value P |
| duty_i | input | CNT_W (16) | Duty compare value D |
| pwm_o | output | 1 | Waveform output |

## Verification
The enable is registered once inside the block, so the counter holds at 0 for the cycle after the enabling edge. The first step then lands X edges later, and the output follows the counter in that same cycle because the comparison is combinational. The bench therefore counts master-clock edges from the enabling edge, derives the expected step index as edges divided by X, and samples on the falling clock edge to compare against a model of both counting shapes. A disable shows up at the output one edge after `en_i` falls, and register changes show up from the first sample after the wrapping edge. Both are checked at exactly those samples.

// File: rtl/pwm_pkg.sv
// Shared constants for the PWM channel: step-source encoding and widths.
// Assumes the prescale ladder is contiguous from divide-by-1 upward.
package pwm_pkg;

    // Number of power-of-two prescale settings (divide by 1 .. 2^(NUM_DIV-1))
    localparam int NUM_DIV = 11;
    // Width of the step-source select field
    localparam int SEL_W   = 4;
    // Width of the free-running prescale counter
    localparam int PRE_W   = NUM_DIV - 1;

    // Select codes above the prescale ladder
    localparam logic [SEL_W-1:0] SEL_STROBE_A = SEL_W'(NUM_DIV);
    localparam logic [SEL_W-1:0] SEL_STROBE_B = SEL_W'(NUM_DIV + 1);

    // Source decoded from the select field
    typedef enum logic [1:0] {
        SRC_PRESCALE = 2'd0,
        SRC_STROBE_A = 2'd1,
        SRC_STROBE_B = 2'd2,
        SRC_STOPPED  = 2'd3
    } step_src_e;

    // Map a select code to its source class
    function automatic step_src_e decode_sel(input logic [SEL_W-1:0] sel);
        if (sel < SEL_W'(NUM_DIV))   return SRC_PRESCALE;
        else if (sel == SEL_STROBE_A) return SRC_STROBE_A;
        else if (sel == SEL_STROBE_B) return SRC_STROBE_B;
        else                          return SRC_STOPPED;
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
// Step-tick generator. A free-running prescale counter runs while the channel
// is running and is cleared while it is idle. The output tick is one cycle wide.
// Assumes run_i is the registered enable, so the first prescaled tick comes
// 2^sel cycles after the enabling edge.
module pwm_tick_gen
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             tick_a_i,
    input  logic             tick_b_i,
    output logic             tick_o
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_mask;
    logic             pre_hit;
    step_src_e        src;

    // Prescale counter: counts while running, restarts from zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n)      pre_q <= '0;
        else if (!run_i) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    // Low-bit mask for the chosen division; code 0 gives an empty mask (every cycle)
    always_comb begin
        pre_mask = '0;
        if (sel_i < SEL_W'(NUM_DIV))
            pre_mask = ~({PRE_W{1'b1}} << sel_i);
    end

    assign pre_hit = ((pre_q & pre_mask) == pre_mask);
    assign src     = decode_sel(sel_i);

    // Pick the step strobe from the decoded source
    always_comb begin
        unique case (src)
            SRC_PRESCALE: tick_o = run_i & pre_hit;
            SRC_STROBE_A: tick_o = run_i & tick_a_i;
            SRC_STROBE_B: tick_o = run_i & tick_b_i;
            default:      tick_o = 1'b0;
        endcase
    end

    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !tick_o); // R10
    AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i > SEL_STROBE_B) |-> !tick_o); // R6

endmodule

// File: rtl/pwm_counter.sv
// Channel counter with latched period, duty and shape. In edge-aligned shape it
// wraps from P-1 to 0. In center-aligned shape it climbs to P and falls to 0.
// The configuration is captured when the count returns to 0 and while disabled.
// Assumes tick_i is at most one cycle wide and already gated by run.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic             center_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             down_o,
    output logic [CNT_W-1:0] duty_o
);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             down_q, down_d;
    logic [CNT_W-1:0] per_q, dty_q;
    logic             ctr_q;
    logic             load;

    // Next-state of count and direction, plus the period-start capture strobe
    always_comb begin
        cnt_d  = cnt_q;
        down_d = down_q;
        load   = 1'b0;
        if (!en_i) begin
            cnt_d  = '0;
            down_d = 1'b0;
            load   = 1'b1;
        end else if (tick_i) begin
            if (per_q == '0) begin
                cnt_d  = '0;
                down_d = 1'b0;
                load   = 1'b1;
            end else if (!ctr_q) begin
                if (cnt_q >= per_q - 1'b1) begin
                    cnt_d = '0;
                    load  = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end else if (!down_q) begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q >= per_q - 1'b1)
                    down_d = 1'b1;
            end else begin
                if (cnt_q <= CNT_W'(1)) begin
                    cnt_d  = '0;
                    down_d = 1'b0;
                    load   = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        end
    end

    // Count and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            down_q <= down_d;
        end
    end

    // Configuration captured at the start of each period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            dty_q <= '0;
            ctr_q <= 1'b0;
        end else if (load) begin
            per_q <= period_i;
            dty_q <= duty_i;
            ctr_q <= center_i;
        end
    end

    assign cnt_o  = cnt_q;
    assign down_o = down_q;
    assign duty_o = dty_q;

    AST_EDGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctr_q && per_q != '0) |-> (cnt_q < per_q)); // R2
    AST_CENTER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q |-> (cnt_q <= per_q)); // R3
    AST_CENTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q && per_q != '0 && cnt_q == per_q) |-> down_q); // R3
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (cnt_q == '0) || ($stable(per_q) && $stable(dty_q) && $stable(ctr_q))); // R9
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0 && !down_q)); // R10

endmodule

// File: rtl/pwm_out_stage.sv
// Output comparator. Active while count >= duty on the rising half and while
// count > duty on the falling half. Drives the inactive level when not running.
// Assumes down_i stays low in edge-aligned shape.
module pwm_out_stage #(
    parameter int CNT_W = 16
) (
    input  logic             run_i,
    input  logic             pol_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             down_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             pwm_o
);

    logic active;

    // Compare count against latched duty with the half-dependent bound
    always_comb begin
        if (down_i) active = (cnt_i >  duty_i);
        else        active = (cnt_i >= duty_i);
    end

    // Map active/inactive onto the selected polarity
    assign pwm_o = (run_i && active) ? pol_i : ~pol_i;

endmodule

// File: rtl/pwm_channel.sv
// Top of the PWM channel: registers the enable, generates the step tick,
// runs the channel counter and drives the compared output.
// Assumes the external strobes are synchronous to clk and one cycle wide.
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             center_i,
    input  logic             pol_i,
    input  logic [SEL_W-1:0] clk_sel_i,
    input  logic             tick_a_i,
    input  logic             tick_b_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             pwm_o
);

    logic             run_q;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             down;
    logic [CNT_W-1:0] duty_l;

    // Registered enable: channel runs from the edge after en_i is seen high
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= en_i;
    end

    pwm_tick_gen u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run_q & en_i),
        .sel_i    (clk_sel_i),
        .tick_a_i (tick_a_i),
        .tick_b_i (tick_b_i),
        .tick_o   (tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .tick_i   (tick),
        .center_i (center_i),
        .period_i (period_i),
        .duty_i   (duty_i),
        .cnt_o    (cnt),
        .down_o   (down),
        .duty_o   (duty_l)
    );

    pwm_out_stage #(.CNT_W(CNT_W)) u_out (
        .run_i  (run_q),
        .pol_i  (pol_i),
        .cnt_i  (cnt),
        .down_i (down),
        .duty_i (duty_l),
        .pwm_o  (pwm_o)
    );

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && clk_sel_i > SEL_STROBE_B) |=> $stable(cnt)); // R6
    AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (pwm_o == ~pol_i)); // R1

endmodule

// File: tb/pwm_channel_bench.sv
// Directed bench for pwm_channel: one task per scenario, sampled on falling edges.
module pwm_channel_bench;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic          center;
    logic          pol;
    logic [3:0]    sel;
    logic          ta;
    logic          tb_s;
    logic [CW-1:0] per;
    logic [CW-1:0] dty;
    logic          pwm;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwm_channel #(.CNT_W(CW)) u_pwm_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en),
        .center_i  (center),
        .pol_i     (pol),
        .clk_sel_i (sel),
        .tick_a_i  (ta),
        .tick_b_i  (tb_s),
        .period_i  (per),
        .duty_i    (dty),
        .pwm_o     (pwm)
    );

    // Record one comparison
    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pwm_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Model: is the output active at step index m for the given shape?
    function automatic bit model_active(input bit ctr, input int p, input int d, input int m);
        int t;
        int c;
        if (p == 0) return (d == 0);
        if (!ctr) begin
            c = m % p;
            return c >= d;
        end
        t = m % (2 * p);
        if (t < p) return t >= d;
        c = 2 * p - t;
        return c > d;
    endfunction

    // Configure, enable, and compare n samples against the model
    task automatic run_pattern(input string req, input bit ctr, input int code,
                               input int p, input int d, input bit pl, input int n);
        int x;
        x = 1 << code;
        en = 1'b0; center = ctr; sel = 4'(code); per = CW'(p); dty = CW'(d); pol = pl;
        @(negedge clk);
        en = 1'b1;
        @(posedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, pwm, model_active(ctr, p, d, i / x) ? pl : ~pl);
        end
        en = 1'b0;
        @(negedge clk);
    endtask

    // R1: reset and idle level
    task automatic t_reset;
        rst_n = 1'b0; en = 1'b0; center = 1'b0; pol = 1'b1; sel = 4'd0;
        ta = 1'b0; tb_s = 1'b0; per = CW'(4); dty = CW'(1);
        repeat (3) @(negedge clk);
        chk("R1 reset level pol=1", pwm, 1'b0);
        pol = 1'b0;
        #1 chk("R1 reset level pol=0", pwm, 1'b1);
        rst_n = 1'b1;
        pol = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", pwm, 1'b0);
    endtask

    // R5: external strobes, only the selected one steps the counter
    task automatic t_strobe(input int code);
        string req;
        req = (code == 11) ? "R5 strobe A" : "R5 strobe B";
        en = 1'b0; center = 1'b0; sel = 4'(code); per = CW'(2); dty = CW'(1); pol = 1'b1;
        @(negedge clk);
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(req, pwm, 1'b0);
        if (code == 11) tb_s = 1'b1; else ta = 1'b1;
        @(negedge clk);
        ta = 1'b0; tb_s = 1'b0;
        @(negedge clk);
        chk({req, " other strobe ignored"}, pwm, 1'b0);
        if (code == 11) ta = 1'b1; else tb_s = 1'b1;
        @(negedge clk);
        ta = 1'b0; tb_s = 1'b0;
        chk({req, " step to 1"}, pwm, 1'b1);
        repeat (3) @(negedge clk);
        chk({req, " holds without strobe"}, pwm, 1'b1);
        if (code == 11) ta = 1'b1; else tb_s = 1'b1;
        @(negedge clk);
        ta = 1'b0; tb_s = 1'b0;
        chk({req, " wrap to 0"}, pwm, 1'b0);
        en = 1'b0;
        @(negedge clk);
    endtask

    // R6: reserved select codes stop the counter
    task automatic t_stopped;
        en = 1'b0; center = 1'b0; sel = 4'd14; per = CW'(2); dty = CW'(1); pol = 1'b1;
        @(negedge clk);
        en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            ta = i[0]; tb_s = ~i[0];
            @(negedge clk);
            chk("R6 stopped counter", pwm, 1'b0);
        end
        ta = 1'b0; tb_s = 1'b0;
        en = 1'b0;
        @(negedge clk);
    endtask

    // R9: mid-period changes wait for the next period
    task automatic t_shadow;
        en = 1'b0; center = 1'b0; sel = 4'd0; per = CW'(8); dty = CW'(2); pol = 1'b1;
        @(negedge clk);
        en = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 13; i++) begin
            @(negedge clk);
            if (i < 8) chk("R9 old values kept", pwm, (i >= 2));
            else       chk("R9 new values used", pwm, ((i - 8) >= 3));
            if (i == 3) begin
                per = CW'(5);
                dty = CW'(3);
            end
        end
        en = 1'b0;
        @(negedge clk);
    endtask

    // R10: disable forces inactive and clears the counter; R7 polarity acts at once
    task automatic t_disable;
        en = 1'b0; center = 1'b0; sel = 4'd0; per = CW'(6); dty = CW'(0); pol = 1'b1;
        @(negedge clk);
        en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 running active", pwm, 1'b1);
        pol = 1'b0;
        #1 chk("R7 polarity immediate", pwm, 1'b0);
        pol = 1'b1;
        en = 1'b0;
        @(negedge clk);
        chk("R10 inactive after disable", pwm, 1'b0);
        dty = CW'(2);
        @(negedge clk);
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R10 restart at 0 (count 0)", pwm, 1'b0);
        @(negedge clk);
        chk("R10 restart at 0 (count 1)", pwm, 1'b0);
        @(negedge clk);
        chk("R10 restart at 0 (count 2)", pwm, 1'b1);
        en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        run_pattern("R2 edge div1 P10 D3", 1'b0, 0, 10, 3, 1'b1, 30);
        run_pattern("R4 edge div4 P5 D2", 1'b0, 2, 5, 2, 1'b1, 45);
        run_pattern("R4 edge div1024 P2 D1", 1'b0, 10, 2, 1, 1'b1, 4200);
        run_pattern("R3 center div1 P4 D1", 1'b1, 0, 4, 1, 1'b1, 24);
        run_pattern("R3 center div2 P5 D3", 1'b1, 1, 5, 3, 1'b1, 40);
        run_pattern("R8 center D0 full", 1'b1, 1, 3, 0, 1'b1, 24);
        run_pattern("R8 edge D=P empty", 1'b0, 0, 4, 4, 1'b1, 16);
        run_pattern("R8 center D>P empty", 1'b1, 0, 4, 5, 1'b1, 16);
        run_pattern("R7 inverted polarity", 1'b0, 0, 6, 2, 1'b0, 18);
        t_strobe(11);
        t_strobe(12);
        t_stopped();
        t_shadow();
        t_disable();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule